// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words and reports whether the first is greater than, equal to, or less than the second. It is built from identical 4-bit comparator slices. Each slice decides on its own nibble and, when its two nibbles match, passes on the verdict of the next less-significant slice. This lets any number of slices chain into a wider comparator.

The top level chains three slices into a 12-bit comparator. The least-significant slice is seeded with a neutral "equal so far" verdict. The whole block is combinational and has no clock or reset. Its outputs follow the operands after the propagation delay through the slice chain.

Top module: `mag_cmp_chain`

## Requirements
- R1: `gt_o` is 1 exactly when `a_i` is greater than `b_i`, with both read as unsigned binary words whose bit 11 is the most significant.
- R2: `eq_o` is 1 exactly when every bit of `a_i` matches the same bit of `b_i`.
- R3: `lt_o` is 1 exactly when `a_i` is less than `b_i` as unsigned words.
- R4: For every operand pair, exactly one of `gt_o`, `eq_o` and `lt_o` is 1.
- R5: When the most significant nibbles (bits 11..8) differ, they alone decide the result, whatever the lower bits hold.
- R6: When the upper nibbles match, the result comes from the lower nibbles. A difference in bit 0 alone still decides the result.
- R7: The extreme operands compare correctly: all-zero against all-zero and all-one against all-one give equal, and zero against all-one gives less.
- R8: The comparison is unsigned. A word with bit 11 set ranks above every word with bit 11 clear; for example, 0x800 is greater than 0x7FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 12 | First operand, unsigned |
| b_i | input | 12 | Second operand, unsigned |
| gt_o | output | 1 | First operand is greater |
| eq_o | output | 1 | Operands are equal |
| lt_o | output | 1 | First operand is less |

## Verification
On every change of the operands, the checker tests that each output agrees with the native unsigned relation of the two words. It also tests that exactly one output is set. Those checks say nothing about which slice decided the result, so only the bench's directed scenarios can show it. These scenarios make the top nibble override contradictory lower bits and make a single differing bit 0 decide between otherwise equal words. They also cover the all-zero, all-one and sign-bit boundaries that show the comparison is unsigned.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cmp_res_t;

    localparam cmp_res_t CASC_SEED = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/cmp_core.sv
module cmp_core #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         a_gt_b,
    output logic         a_eq_b
);

    logic [W:0] eq_run;

    assign eq_run[0] = 1'b1;

    generate
        for (genvar i = 0; i < W; i++) begin : g_eq
            assign eq_run[i+1] = eq_run[i] & ~(a[i] ^ b[i]);
        end
    endgenerate

    assign a_eq_b = eq_run[W];

    always_comb begin
        logic decided;
        decided = 1'b0;
        a_gt_b  = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!decided && (a[i] != b[i])) begin
                decided = 1'b1;
                a_gt_b  = a[i];
            end
        end
    end

endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
    import magcmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  cmp_res_t     cin,
    output cmp_res_t     cout
);

    logic loc_gt;
    logic loc_eq;
    logic loc_lt;

    cmp_core #(.W(W)) u_core (
        .a      (a),
        .b      (b),
        .a_gt_b (loc_gt),
        .a_eq_b (loc_eq)
    );

    assign loc_lt = ~loc_gt & ~loc_eq;

    always_comb begin
        cout.gt = loc_gt | (loc_eq & cin.gt);
        cout.eq = loc_eq & cin.eq;
        cout.lt = loc_lt | (loc_eq & cin.lt);
    end

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
    import magcmp_pkg::*;
#(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 3
) (
    input  logic [SLICE_W*NUM_SLICES-1:0] a_i,
    input  logic [SLICE_W*NUM_SLICES-1:0] b_i,
    output logic                          gt_o,
    output logic                          eq_o,
    output logic                          lt_o
);

    localparam int WORD_W = SLICE_W * NUM_SLICES;

    cmp_res_t link [NUM_SLICES+1];

    assign link[0] = CASC_SEED;

    generate
        for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
            cmp_slice #(.W(SLICE_W)) u_slice (
                .a    (a_i[s*SLICE_W +: SLICE_W]),
                .b    (b_i[s*SLICE_W +: SLICE_W]),
                .cin  (link[s]),
                .cout (link[s+1])
            );
        end
    endgenerate

    assign gt_o = link[NUM_SLICES].gt;
    assign eq_o = link[NUM_SLICES].eq;
    assign lt_o = link[NUM_SLICES].lt;

endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
    parameter int WORD_W = 12
) (
    input logic [WORD_W-1:0] a_i,
    input logic [WORD_W-1:0] b_i,
    input logic              gt_o,
    input logic              eq_o,
    input logic              lt_o
);

    always_comb begin
        a_r1_gt_matches: assert (gt_o == (a_i > b_i));
        a_r2_eq_matches: assert (eq_o == (a_i == b_i));
        a_r3_lt_matches: assert (lt_o == (a_i < b_i));
        a_r4_one_hot:    assert ($countones({gt_o, eq_o, lt_o}) == 1);
    end

endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.WORD_W(WORD_W)) u_chk (
    .a_i  (a_i),
    .b_i  (b_i),
    .gt_o (gt_o),
    .eq_o (eq_o),
    .lt_o (lt_o)
);

// File: tb/mag_cmp_chain_tb.sv
module mag_cmp_chain_tb;

    localparam int W = 12;

    typedef struct {
        logic [2:0] res;
        logic [W-1:0] a;
        logic [W-1:0] b;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic gt_o, eq_o, lt_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    mag_cmp_chain u_dut (
        .a_i  (a_i),
        .b_i  (b_i),
        .gt_o (gt_o),
        .eq_o (eq_o),
        .lt_o (lt_o)
    );

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        a_i = a;
        b_i = b;
        e.res = {a > b, a == b, a < b};
        e.a = a;
        e.b = b;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if ({gt_o, eq_o, lt_o} !== e.res) begin
                n_fails++;
                $display("FAIL %s a=%h b=%h actual gt/eq/lt=%b expected=%b",
                         e.tag, e.a, e.b, {gt_o, eq_o, lt_o}, e.res);
            end
            n_checks++;
            if ($countones({gt_o, eq_o, lt_o}) != 1) begin
                n_fails++;
                $display("FAIL R4 a=%h b=%h actual gt/eq/lt=%b expected one-hot",
                         e.a, e.b, {gt_o, eq_o, lt_o});
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-time operands: both zero, equal (R2, R7)
        drive(12'h000, 12'h000, "R2 R7 zero vs zero");
        drive(12'hFFF, 12'hFFF, "R2 R7 ones vs ones");
        drive(12'h000, 12'hFFF, "R3 R7 zero vs ones");
        drive(12'hFFF, 12'h000, "R1 R7 ones vs zero");
        // R5: top nibble decides against contradictory lower bits
        drive(12'h100, 12'h0FF, "R5 top nibble greater");
        drive(12'h5FF, 12'h600, "R5 top nibble less");
        // R6: upper nibbles equal, lowest bit decides
        drive(12'hAB5, 12'hAB4, "R6 bit0 greater");
        drive(12'hAB4, 12'hAB5, "R6 bit0 less");
        drive(12'h3C7, 12'h3D0, "R6 middle nibble less");
        drive(12'h3E0, 12'h3DF, "R6 middle nibble greater");
        // R8: unsigned ordering across bit 11
        drive(12'h800, 12'h7FF, "R8 sign bit ranks high");
        drive(12'h7FF, 12'h800, "R8 sign bit reverse");
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = (i % 4 == 0) ? ra : W'($urandom);
            if (i % 8 == 1) rb = {ra[W-1:4], rb[3:0]};
            drive(ra, rb, "R1 R2 R3 random");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule